// File: doc/BRIEF.md
# Bonded Read-Return Merger

This block rejoins a logical read word that was split across two memory controllers. Each controller returns its own slice of the word on a separate valid/data stream. The two slices may have different widths, because the split follows the width of each controller's memory. The two streams are independently timed but stay in request order. Each side feeds a small buffer of its own, and an occupancy counter tracks how many words that buffer holds. A combined beat goes out only in a cycle where both counters are non-zero. The beat is formed by concatenating the two buffer heads, so side A is in the low-order bits and side B is above it.

The side inputs cannot be stalled, since a controller pushes a returning word whenever it has one. The merged output is a valid/ready stream toward one bus master. While `m_valid` is high and `m_ready` is low, the beat is held unchanged and neither buffer advances. A beat is consumed in any cycle where `m_valid` and `m_ready` are both high. Both sides share one clock. The sum of the two slice widths must lie between 64 and 256 bits, and any other sum stops elaboration with an error.

Top module: `bond_rd_merge`

## Requirements
- R1: Synchronous active-high reset empties both buffers, drives `m_valid` low and clears both overflow flags.
- R2: `m_data` equals {side B word, side A word}, with side A in bits [A_W-1:0] and side B in bits [A_W+B_W-1:A_W].
- R3: `m_valid` is high only while both buffers hold at least one word. A word on one side alone never produces a beat.
- R4: Words pair strictly in arrival order. The k-th accepted word of side A is emitted with the k-th accepted word of side B.
- R5: A side that runs ahead of its partner keeps up to DEPTH early words and emits each of them later with its partner. None is lost.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays unchanged on the next cycle.
- R7: A word that arrives on a side whose buffer holds DEPTH words, in a cycle with no beat consumed, is discarded. The buffered words are kept and that side's overflow flag is set. The other side's flag is unaffected.
- R8: An overflow flag, once set, stays set until reset.
- R9: A word that arrives on a full side in the same cycle a beat is consumed is accepted, and it does not set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides and the master |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Side A word present this cycle |
| a_data | input | A_W | Side A slice |
| b_valid | input | 1 | Side B word present this cycle |
| b_data | input | B_W | Side B slice |
| m_valid | output | 1 | Merged beat available |
| m_ready | input | 1 | Master accepts the merged beat |
| m_data | output | A_W+B_W | Merged beat {B, A} |
| a_ovf | output | 1 | Sticky: side A word discarded |
| b_ovf | output | 1 | Sticky: side B word discarded |

## Verification
The bench builds the block with asymmetric slices (A_W=24, B_W=40), so that a swapped or misaligned concatenation shows up as a miscompare. It uses DEPTH=4, so a few pushes from one side alone fill a buffer. This makes the discard path, the sticky flags and the accepted push during a pop on a full buffer reachable in a short run. Stall windows with both buffers full also exercise holding the beat under back-pressure.

// File: rtl/bond_pkg.sv
package bond_pkg;
  localparam int unsigned MERGED_MIN_W = 64;
  localparam int unsigned MERGED_MAX_W = 256;

  function automatic int unsigned occ_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/bond_side_fifo.sv
module bond_side_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = bond_pkg::occ_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          ovf
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, accept, drop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign accept = wr_en && (!full || rd_en);
  assign drop   = wr_en && full && !rd_en;
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (accept) wp <= bump(wp);
      if (rd_en)  rp <= bump(rp);
      case ({accept, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop) ovf <= 1'b1;
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  assert_early_held_R5: assert property (@(posedge clk) disable iff (rst)
    (count != '0 && !rd_en) |=> count != '0);
  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !ovf));
endmodule

// File: rtl/bond_pair_ctrl.sv
module bond_pair_ctrl #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  input  logic          m_ready,
  output logic          m_valid,
  output logic          pop
);
  assign m_valid = (cnt_a != '0) && (cnt_b != '0);
  assign pop     = m_valid && m_ready;

  assert_stall_keeps_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> m_valid);
endmodule

// File: rtl/bond_rd_merge.sv
module bond_rd_merge #(
  parameter int unsigned A_W   = 32,
  parameter int unsigned B_W   = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_valid,
  input  logic [A_W-1:0]   a_data,
  input  logic             b_valid,
  input  logic [B_W-1:0]   b_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [A_W+B_W-1:0] m_data,
  output logic             a_ovf,
  output logic             b_ovf
);
  localparam int unsigned MW = A_W + B_W;
  localparam int unsigned CW = bond_pkg::occ_width(DEPTH);

  if (MW < bond_pkg::MERGED_MIN_W || MW > bond_pkg::MERGED_MAX_W
      || A_W == 0 || B_W == 0 || DEPTH == 0) begin : g_width_bad
    $error("bond_rd_merge: merged width must be 64..256 with non-empty slices");
  end

  logic [A_W-1:0] a_head;
  logic [B_W-1:0] b_head;
  logic [CW-1:0]  a_cnt, b_cnt;
  logic           pop;

  bond_side_fifo #(.W(A_W), .DEPTH(DEPTH), .CW(CW)) u_side_a (
    .clk, .rst, .wr_en(a_valid), .wr_data(a_data), .rd_en(pop),
    .head(a_head), .count(a_cnt), .ovf(a_ovf));

  bond_side_fifo #(.W(B_W), .DEPTH(DEPTH), .CW(CW)) u_side_b (
    .clk, .rst, .wr_en(b_valid), .wr_data(b_data), .rd_en(pop),
    .head(b_head), .count(b_cnt), .ovf(b_ovf));

  bond_pair_ctrl #(.CW(CW)) u_pair (
    .clk, .rst, .cnt_a(a_cnt), .cnt_b(b_cnt), .m_ready,
    .m_valid, .pop);

  assign m_data = {b_head, a_head};

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> $stable(m_data));
  assert_pair_only_R3: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (a_cnt != '0 && b_cnt != '0));
endmodule

// File: tb/bond_rd_merge_bench.sv
module bond_rd_merge_bench;
  localparam int unsigned A_W = 24;
  localparam int unsigned B_W = 40;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned MW = A_W + B_W;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG = 20000;

  logic clk = 1'b0, rst = 1'b1;
  logic a_valid = 0, b_valid = 0, m_ready = 0;
  logic [A_W-1:0] a_data = '0;
  logic [B_W-1:0] b_data = '0;
  logic m_valid, a_ovf, b_ovf;
  logic [MW-1:0] m_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [A_W-1:0] exp_a[$];
  logic [B_W-1:0] exp_b[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bond_rd_merge #(.A_W(A_W), .B_W(B_W), .DEPTH(DEPTH)) u_bond_rd_merge (
    .clk, .rst, .a_valid, .a_data, .b_valid, .b_data,
    .m_valid, .m_ready, .m_data, .a_ovf, .b_ovf);

  task automatic check(input bit ok, input string req,
                       input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  // Monitor: scoreboard compare of each consumed beat (R2, R4, R3)
  always @(negedge clk) begin
    if (!rst && m_valid && m_ready) begin
      if (exp_a.size() == 0 || exp_b.size() == 0) begin
        check(1'b0, "R3 beat without pair", m_data, '0);
      end else begin
        check(m_data == {exp_b[0], exp_a[0]}, "R2/R4 merged beat",
              m_data, {exp_b[0], exp_a[0]});
        void'(exp_a.pop_front());
        void'(exp_b.pop_front());
      end
    end
  end

  task automatic drive(input bit av, input logic [A_W-1:0] ad,
                       input bit bv, input logic [B_W-1:0] bd,
                       input bit keep_a, input bit keep_b, input bit rdy);
    @(posedge clk); #1;
    a_valid = av; a_data = ad; b_valid = bv; b_data = bd; m_ready = rdy;
    if (av && keep_a) exp_a.push_back(ad);
    if (bv && keep_b) exp_b.push_back(bd);
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int i = 0; i < n; i++) drive(0, '0, 0, '0, 0, 0, rdy);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1; a_valid = 0; b_valid = 0; m_ready = 0;
    exp_a.delete(); exp_b.delete();
    repeat (2) @(posedge clk);
    #1 rst = 0;
  endtask

  logic [MW-1:0] held;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!m_valid, "R1 m_valid after reset", MW'(m_valid), '0);
    check(!a_ovf, "R1 a_ovf after reset", MW'(a_ovf), '0);
    check(!b_ovf, "R1 b_ovf after reset", MW'(b_ovf), '0);

    // R3/R5: side A runs ahead, no beat until B arrives
    for (int i = 0; i < 3; i++) drive(1, A_W'(24'hA00 + i), 0, '0, 1, 1, 1);
    idle(3, 1);
    @(negedge clk);
    check(!m_valid, "R3 single side gives no beat", MW'(m_valid), '0);
    for (int i = 0; i < 3; i++) drive(0, '0, 1, B_W'(40'hB0_0000_0000 + i), 1, 1, 1);
    idle(4, 1);
    check(exp_a.size() == 0, "R5 early A words all emitted", MW'(exp_a.size()), '0);

    // B leads, interleaved timing (R4)
    drive(0, '0, 1, B_W'(40'h11_2233_4455), 1, 1, 1);
    drive(0, '0, 1, B_W'(40'h66_7788_99AA), 1, 1, 1);
    drive(1, A_W'(24'h123456), 1, B_W'(40'hBB_CCDD_EEFF), 1, 1, 1);
    drive(1, A_W'(24'h789ABC), 0, '0, 1, 1, 1);
    drive(1, A_W'(24'hDEF012), 0, '0, 1, 1, 1);
    idle(4, 1);
    check(exp_a.size() == 0 && exp_b.size() == 0, "R4 interleaved drained",
          MW'(exp_a.size() + exp_b.size()), '0);

    // R6 back-pressure
    drive(1, A_W'(24'h555555), 1, B_W'(40'hAA_AAAA_AAAA), 1, 1, 0);
    drive(1, A_W'(24'h333333), 1, B_W'(40'hCC_CCCC_CCCC), 1, 1, 0);
    idle(1, 0);
    @(negedge clk);
    held = m_data;
    check(m_valid, "R6 valid while stalled", MW'(m_valid), MW'(1));
    check(held == {40'hAA_AAAA_AAAA, 24'h555555}, "R6 head beat", held,
          {40'hAA_AAAA_AAAA, 24'h555555});
    idle(3, 0);
    @(negedge clk);
    check(m_valid && m_data == held, "R6 beat held", m_data, held);
    idle(4, 1);
    check(exp_a.size() == 0, "R6 drained after release", MW'(exp_a.size()), '0);

    // R7 overflow on side A
    for (int i = 0; i < DEPTH; i++) drive(1, A_W'(24'hF00 + i), 0, '0, 1, 1, 1);
    drive(1, A_W'(24'hDEAD), 0, '0, 0, 1, 1);   // discarded
    idle(1, 1);
    @(negedge clk);
    check(a_ovf, "R7 a_ovf set", MW'(a_ovf), MW'(1));
    check(!b_ovf, "R7 b_ovf untouched", MW'(b_ovf), '0);
    check(!m_valid, "R7 no beat without B", MW'(m_valid), '0);
    for (int i = 0; i <= DEPTH; i++) drive(0, '0, 1, B_W'(40'hE0_0000_0000 + i), 1, 1, 1);
    idle(3, 1);
    check(exp_b.size() == 1, "R7 extra B word held", MW'(exp_b.size()), MW'(1));
    drive(1, A_W'(24'h0B0B0B), 0, '0, 1, 1, 1);
    idle(3, 1);
    @(negedge clk);
    check(a_ovf, "R8 a_ovf still set", MW'(a_ovf), MW'(1));
    check(exp_b.size() == 0, "R7 late pair emitted", MW'(exp_b.size()), '0);

    do_reset();
    @(negedge clk);
    check(!a_ovf && !m_valid, "R1 reset clears flag", MW'({a_ovf, m_valid}), '0);

    // R9 push on full side during a pop
    for (int i = 0; i < DEPTH; i++)
      drive(1, A_W'(24'h900 + i), 1, B_W'(40'h90_0000_0000 + i), 1, 1, 0);
    drive(1, A_W'(24'h9FF), 1, B_W'(40'h9F_FFFF_FFFF), 1, 1, 1);
    idle(DEPTH + 3, 1);
    @(negedge clk);
    check(!a_ovf && !b_ovf, "R9 no overflow on push during pop",
          MW'({a_ovf, b_ovf}), '0);
    check(exp_a.size() == 0 && exp_b.size() == 0, "R9 all pairs delivered",
          MW'(exp_a.size() + exp_b.size()), '0);

    finish_run();
  end
endmodule